// File: doc/BRIEF.md
# Streaming CRC Generator

This block computes a cyclic redundancy checksum over packets that arrive one word per cycle on a streaming input. Each input word carries a valid flag, start-of-packet and end-of-packet markers, and an empty count that says how many symbols at the tail of the final word carry no data. The word is cut into equal symbols. Before the division, the symbols can be put in reverse order, and the bits inside each symbol can be reversed. The divider takes the reordered word from its highest bit to its lowest.

The accumulator is preset at every start of packet. A fixed number of leading bits of the first word can be left out of the sum. When the final word has been taken, the remainder is finished and presented together with a strobe that lasts one cycle. The finishing step can complement the remainder, mirror it end to end, or do both. Optional register stages on the input and on the output trade latency for timing. The polynomial, the widths and every option are parameters, so a system integrator sets them once per instance.

Top module: `crc_stream_gen`

## Requirements
- R1: The symbol width is DATA_W/SYMS. With BIT_LSB_FIRST set, the bits inside each symbol are reversed before division. Symbols keep their places. Example: with 12 bits in three 4-bit symbols, "abcd efgh ijkl" is divided as "dcba hgfe lkji".
- R2: With SYM_LSB_FIRST set, the order of the symbols in the word is reversed before division, and the bits inside each symbol keep their order ("abcd efgh ijkl" becomes "ijkl efgh abcd").
- R3: With both reordering options set, the word is divided in fully reversed bit order: bit 0 of in_data first, bit DATA_W-1 last.
- R4: Division is MSB-first on the reordered word. Each step feeds back the accumulator MSB XOR the data bit, shifts left, and XORs in POLY when the feedback is 1. The accumulator is loaded with INIT_VAL on every accepted word that has in_sop set. With the defaults, the nine bytes "123456789" give 0xFC891918.
- R5: On a start-of-packet word, the first SKIP_BITS bits of the reordered word (counted from its MSB) are excluded from the division.
- R6: On an end-of-packet word, the last in_empty symbols of the reordered word (its in_empty*SYM_W lowest bits) are excluded. When skipped and empty bits cover the whole word, that word adds nothing.
- R7: With NEGATE set, crc_out is the one's complement of the remainder.
- R8: With BIT_SWAP set, crc_out is the remainder mirrored, so remainder bit 0 appears at crc_out bit CRC_W-1. With BIT_LSB_FIRST, BIT_SWAP and NEGATE set, "123456789" gives 0xCBF43926.
- R9: A cycle with in_valid low changes neither the accumulator nor the output, whatever its other inputs carry. This includes in_sop and in_eop.
- R10: crc_valid is high for exactly one cycle for each accepted end-of-packet word. It rises 1+REG_IN+REG_OUT clock edges after the edge that takes that word, and it never rises at any other time.
- R11: While rst is high and after its release, crc_valid stays low until a packet has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Data word |
| in_valid | input | 1 | Word qualifier |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_empty | input | EMPTY_W | Count of unused trailing symbols on the last word |
| crc_out | output | CRC_W | Finished checksum, meaningful while crc_valid is high |
| crc_valid | output | 1 | One-cycle strobe for crc_out |

## Verification
The checksum and its strobe are due 1+REG_IN+REG_OUT rising edges after the edge that takes an end-of-packet word: one edge for the accumulator, plus one for each register stage that is enabled. Four instances with different option sets share one stimulus stream, and their latencies range from 1 to 3. When the bench drives a final word, it stores the expected checksum for each instance and the cycle number at which it is due. The bench samples 2 ns after each rising edge. There it matches every strobe against the oldest stored entry, in both value and cycle. Any entry still pending after its due cycle, and any strobe with no entry waiting, fails the check.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;

    // Control bits that travel with every data word.
    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
    } beat_ctl_t;

    // Width needed to count 0..n-1 symbols, at least one bit.
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/crc_in_stage.sv
module crc_in_stage
    import crc_stream_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int EMPTY_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  in_data,
    input  beat_ctl_t          in_ctl,
    input  logic [EMPTY_W-1:0] in_empty,
    output logic [DATA_W-1:0]  out_data,
    output beat_ctl_t          out_ctl,
    output logic [EMPTY_W-1:0] out_empty
);

    typedef struct packed {
        logic [DATA_W-1:0]  data;
        beat_ctl_t          ctl;
        logic [EMPTY_W-1:0] empty;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d       = stage_q;
        stage_d.data  = in_data;
        stage_d.ctl   = in_ctl;
        stage_d.empty = in_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_data  = stage_q.data;
    assign out_ctl   = stage_q.ctl;
    assign out_empty = stage_q.empty;

    // R10: a registered valid word is always one that arrived the cycle before
    a_r10_stage_delay: assert property (@(posedge clk) disable iff (rst)
        out_ctl.valid |-> $past(in_ctl.valid));

endmodule

// File: rtl/crc_reorder.sv
module crc_reorder #(
    parameter int DATA_W = 32,
    parameter int SYMS   = 4,
    parameter bit BIT_REV = 1'b0,
    parameter bit SYM_REV = 1'b0
) (
    input  logic [DATA_W-1:0] in_word,
    output logic [DATA_W-1:0] out_word
);

    localparam int SYM_W = DATA_W / SYMS;

    for (genvar s = 0; s < SYMS; s++) begin : g_sym
        localparam int DST_S = SYM_REV ? (SYMS - 1 - s) : s;
        for (genvar b = 0; b < SYM_W; b++) begin : g_bit
            localparam int DST_B = BIT_REV ? (SYM_W - 1 - b) : b;
            assign out_word[DST_S*SYM_W + DST_B] = in_word[s*SYM_W + b];
        end
    end

    // R3: both reorderings together mirror the whole word
    always_comb begin
        if (BIT_REV && SYM_REV) begin
            for (int i = 0; i < DATA_W; i++) begin
                a_r3_full_mirror: assert (out_word[i] == in_word[DATA_W-1-i]);
            end
        end
    end

endmodule

// File: rtl/crc_core.sv
module crc_core
    import crc_stream_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter int              SYMS      = 4,
    parameter int              CRC_W     = 32,
    parameter logic [CRC_W-1:0] POLY     = 32'h04C11DB7,
    parameter logic [CRC_W-1:0] INIT_VAL = 32'hFFFFFFFF,
    parameter int              SKIP_BITS = 0,
    parameter int              EMPTY_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  word,
    input  beat_ctl_t          ctl,
    input  logic [EMPTY_W-1:0] empty,
    output logic [CRC_W-1:0]   rem,
    output logic               done
);

    localparam int SYM_W = DATA_W / SYMS;

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] rem;
        logic             done;
    } core_t;

    core_t core_d, core_q;
    logic [DATA_W-1:0] use_bit;
    logic [CRC_W-1:0]  step_crc;

    // Which bits of this word take part in the division.
    always_comb begin
        int lo_i;
        int hi_i;
        lo_i = 0;
        hi_i = DATA_W - 1;
        if (ctl.eop) lo_i = SYM_W * int'(empty);
        if (ctl.sop) hi_i = DATA_W - 1 - SKIP_BITS;
        for (int i = 0; i < DATA_W; i++) begin
            use_bit[i] = (i >= lo_i) && (i <= hi_i);
        end
    end

    // MSB-first division over the enabled bits.
    always_comb begin
        logic fb;
        fb       = 1'b0;
        step_crc = ctl.sop ? INIT_VAL : core_q.acc;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (use_bit[i]) begin
                fb       = step_crc[CRC_W-1] ^ word[i];
                step_crc = {step_crc[CRC_W-2:0], 1'b0};
                if (fb) step_crc = step_crc ^ POLY;
            end
        end
    end

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (ctl.valid) begin
            core_d.acc = step_crc;
            if (ctl.eop) begin
                core_d.rem  = step_crc;
                core_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.acc  <= INIT_VAL;
            core_q.rem  <= '0;
            core_q.done <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign rem  = core_q.rem;
    assign done = core_q.done;

    // R9: an idle cycle leaves the accumulator untouched
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !ctl.valid |=> $stable(core_q.acc));

    // R10: a finished remainder only follows an accepted last word
    a_r10_done_after_eop: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ctl.valid && ctl.eop));

    // R9: the remainder only moves when a packet ends
    a_r9_rem_stable: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rem));

endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage #(
    parameter int CRC_W    = 32,
    parameter bit NEGATE   = 1'b1,
    parameter bit BIT_SWAP = 1'b0,
    parameter bit REG_EN   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CRC_W-1:0] rem,
    input  logic             done,
    output logic [CRC_W-1:0] crc,
    output logic             crc_valid
);

    logic [CRC_W-1:0] fin;

    always_comb begin
        for (int i = 0; i < CRC_W; i++) begin
            fin[i] = (BIT_SWAP ? rem[CRC_W-1-i] : rem[i]) ^ NEGATE;
        end
    end

    if (REG_EN) begin : g_reg
        typedef struct packed {
            logic [CRC_W-1:0] crc;
            logic             vld;
        } out_t;

        out_t out_d, out_q;

        always_comb begin
            out_d     = out_q;
            out_d.vld = done;
            if (done) out_d.crc = fin;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        assign crc       = out_q.crc;
        assign crc_valid = out_q.vld;

        // R10: the output strobe is the previous cycle's done, one edge later
        a_r10_out_delay: assert property (@(posedge clk) disable iff (rst)
            crc_valid |-> $past(done));
    end else begin : g_comb
        assign crc       = fin;
        assign crc_valid = done;
    end

    // R7 and R8: the top output bit comes from the remainder end picked by the swap option
    a_r8_end_bit: assert property (@(posedge clk) disable iff (rst)
        done |-> (fin[CRC_W-1] == ((BIT_SWAP ? rem[0] : rem[CRC_W-1]) ^ NEGATE)));

endmodule

// File: rtl/crc_stream_gen.sv
module crc_stream_gen
    import crc_stream_pkg::*;
#(
    parameter int               DATA_W        = 32,
    parameter int               SYMS          = 4,
    parameter int               CRC_W         = 32,
    parameter logic [CRC_W-1:0] POLY          = 32'h04C11DB7,
    parameter logic [CRC_W-1:0] INIT_VAL      = 32'hFFFFFFFF,
    parameter int               SKIP_BITS     = 0,
    parameter bit               BIT_LSB_FIRST = 1'b0,
    parameter bit               SYM_LSB_FIRST = 1'b0,
    parameter bit               NEGATE        = 1'b1,
    parameter bit               BIT_SWAP      = 1'b0,
    parameter bit               REG_IN        = 1'b0,
    parameter bit               REG_OUT       = 1'b0,
    localparam int              EMPTY_W       = width_of(SYMS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    output logic [CRC_W-1:0]   crc_out,
    output logic               crc_valid
);

    beat_ctl_t          raw_ctl, st_ctl;
    logic [DATA_W-1:0]  st_data, ord_data;
    logic [EMPTY_W-1:0] st_empty;
    logic [CRC_W-1:0]   core_rem;
    logic               core_done;

    assign raw_ctl = '{valid: in_valid, sop: in_sop, eop: in_eop};

    if (REG_IN) begin : g_in_reg
        crc_in_stage #(
            .DATA_W  (DATA_W),
            .EMPTY_W (EMPTY_W)
        ) u_in (
            .clk       (clk),
            .rst       (rst),
            .in_data   (in_data),
            .in_ctl    (raw_ctl),
            .in_empty  (in_empty),
            .out_data  (st_data),
            .out_ctl   (st_ctl),
            .out_empty (st_empty)
        );
    end else begin : g_in_pass
        assign st_data  = in_data;
        assign st_ctl   = raw_ctl;
        assign st_empty = in_empty;
    end

    crc_reorder #(
        .DATA_W  (DATA_W),
        .SYMS    (SYMS),
        .BIT_REV (BIT_LSB_FIRST),
        .SYM_REV (SYM_LSB_FIRST)
    ) u_order (
        .in_word  (st_data),
        .out_word (ord_data)
    );

    crc_core #(
        .DATA_W    (DATA_W),
        .SYMS      (SYMS),
        .CRC_W     (CRC_W),
        .POLY      (POLY),
        .INIT_VAL  (INIT_VAL),
        .SKIP_BITS (SKIP_BITS),
        .EMPTY_W   (EMPTY_W)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .word  (ord_data),
        .ctl   (st_ctl),
        .empty (st_empty),
        .rem   (core_rem),
        .done  (core_done)
    );

    crc_out_stage #(
        .CRC_W    (CRC_W),
        .NEGATE   (NEGATE),
        .BIT_SWAP (BIT_SWAP),
        .REG_EN   (REG_OUT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .rem       (core_rem),
        .done      (core_done),
        .crc       (crc_out),
        .crc_valid (crc_valid)
    );

    // R11: no strobe can be pending in the cycle right after reset
    a_r11_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !crc_valid);

endmodule

// File: tb/crc_stream_gen_tb.sv
module crc_stream_gen_tb;

    // Instance option sets, bit k = instance k (0 u_dut, 1 u_dut_both, 2 u_dut_refl, 3 u_dut_symr)
    localparam logic [3:0] BR_M   = 4'b0110;
    localparam logic [3:0] SR_M   = 4'b1010;
    localparam logic [3:0] NEG_M  = 4'b0101;
    localparam logic [3:0] SWP_M  = 4'b0110;
    localparam logic [31:0] POLY  = 32'h04C11DB7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [1:0]  in_empty = '0;
    logic [31:0] crc_o [4];
    logic        vld_o [4];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] exp_q [4][$];
    int          due_q [4][$];
    logic [31:0] pkt [$];
    string       tags [4] = '{"R4/R6/R7", "R3/R5/R8", "R1/R8/R7", "R2/R5"};

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    crc_stream_gen u_dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty), .crc_out(crc_o[0]), .crc_valid(vld_o[0]));

    crc_stream_gen #(.INIT_VAL(32'h0), .SKIP_BITS(8), .BIT_LSB_FIRST(1'b1), .SYM_LSB_FIRST(1'b1),
        .NEGATE(1'b0), .BIT_SWAP(1'b1), .REG_IN(1'b1), .REG_OUT(1'b1)) u_dut_both (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty), .crc_out(crc_o[1]), .crc_valid(vld_o[1]));

    crc_stream_gen #(.BIT_LSB_FIRST(1'b1), .NEGATE(1'b1), .BIT_SWAP(1'b1), .REG_OUT(1'b1)) u_dut_refl (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty), .crc_out(crc_o[2]), .crc_valid(vld_o[2]));

    crc_stream_gen #(.INIT_VAL(32'h12345678), .SKIP_BITS(4), .SYM_LSB_FIRST(1'b1), .NEGATE(1'b0),
        .REG_IN(1'b1)) u_dut_symr (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty), .crc_out(crc_o[3]), .crc_valid(vld_o[3]));

    function automatic int skip_of(input int k);
        case (k)
            1: return 8;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] init_of(input int k);
        case (k)
            1: return 32'h0;
            3: return 32'h12345678;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic int lat_of(input int k);
        case (k)
            1: return 3;
            0: return 1;
            default: return 2;
        endcase
    endfunction

    // Bit-serial model built from R1..R8
    function automatic logic [31:0] ref_crc(input int k, input logic [31:0] w [$], input int emp);
        logic [31:0] c;
        logic [31:0] p;
        logic [31:0] r;
        logic        fb;
        c = init_of(k);
        for (int n = 0; n < w.size(); n++) begin
            int hi;
            int lo;
            for (int j = 0; j < 32; j++) begin
                int s;
                int b;
                s = SR_M[k] ? 3 - j / 8 : j / 8;
                b = BR_M[k] ? 7 - j % 8 : j % 8;
                p[s*8 + b] = w[n][j];
            end
            hi = (n == 0) ? 31 - skip_of(k) : 31;
            lo = (n == w.size() - 1) ? emp * 8 : 0;
            for (int i = 31; i >= 0; i--) begin
                if (i <= hi && i >= lo) begin
                    fb = c[31] ^ p[i];
                    c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
                end
            end
        end
        for (int i = 0; i < 32; i++) r[i] = SWP_M[k] ? c[31-i] : c[i];
        return NEG_M[k] ? ~r : r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] d, input bit v, input bit s, input bit e, input int emp);
        @(negedge clk);
        in_data  = d;
        in_valid = v;
        in_sop   = s;
        in_eop   = e;
        in_empty = emp[1:0];
    endtask

    // Sends pkt; optional forced expectations for instances 0 and 2
    task automatic send_pkt(input int emp, input bit idles, input bit forced,
                            input logic [31:0] fa, input logic [31:0] fc);
        logic [31:0] expv [4];
        for (int k = 0; k < 4; k++) expv[k] = ref_crc(k, pkt, emp);
        if (forced) begin
            expv[0] = fa;
            expv[2] = fc;
        end
        for (int n = 0; n < pkt.size(); n++) begin
            bit last;
            last = (n == pkt.size() - 1);
            if (idles && ($urandom % 4 == 0))   // R9: idle word with random markers
                send_word($urandom, 1'b0, 1'($urandom), 1'($urandom), int'($urandom % 4));
            send_word(pkt[n], 1'b1, n == 0, last, last ? emp : int'($urandom % 4));
            if (last) begin
                for (int k = 0; k < 4; k++) begin
                    exp_q[k].push_back(expv[k]);
                    due_q[k].push_back(cyc + lat_of(k));
                end
            end
        end
    endtask

    // Output monitor, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            for (int k = 0; k < 4; k++) begin
                if (due_q[k].size() > 0 && due_q[k][0] < cyc) begin
                    check(1'b0, "R10", $sformatf("inst %0d strobe missing", k), 32'(cyc), 32'(due_q[k][0]));
                    void'(exp_q[k].pop_front());
                    void'(due_q[k].pop_front());
                end
                if (vld_o[k]) begin
                    if (exp_q[k].size() == 0) begin
                        check(1'b0, "R9/R10", $sformatf("inst %0d strobe without packet", k), 32'd1, 32'd0);
                    end else begin
                        logic [31:0] e;
                        int d;
                        e = exp_q[k].pop_front();
                        d = due_q[k].pop_front();
                        check(crc_o[k] == e, tags[k], $sformatf("inst %0d checksum", k), crc_o[k], e);
                        check(d == cyc, "R10", $sformatf("inst %0d strobe cycle", k), 32'(cyc), 32'(d));
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not end", 32'(cyc), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++)   // R11: quiet during reset
            check(vld_o[k] == 1'b0, "R11", $sformatf("inst %0d strobe in reset", k), 32'(vld_o[k]), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++)   // R11: quiet after release
            check(vld_o[k] == 1'b0, "R11", $sformatf("inst %0d strobe after reset", k), 32'(vld_o[k]), 32'd0);

        // R4, R8: "123456789" known check values
        pkt = '{32'h31323334, 32'h35363738, 32'h39000000};
        send_pkt(3, 1'b0, 1'b1, 32'hFC891918, 32'hCBF43926);
        send_word('0, 1'b0, 1'b0, 1'b0, 0);

        // R9: idle words carrying markers, no strobe may follow
        send_word(32'hDEADBEEF, 1'b0, 1'b1, 1'b1, 0);
        send_word(32'h01234567, 1'b0, 1'b0, 1'b1, 2);
        send_word('0, 1'b0, 1'b0, 1'b0, 0);
        repeat (5) @(negedge clk);

        // R5, R6: single word where skip and empty leave nothing for some instances
        pkt = '{32'hA5A5A5A5};
        send_pkt(3, 1'b0, 1'b0, '0, '0);
        // back-to-back single-word packets, R10
        pkt = '{32'h0F0F0F0F};
        send_pkt(0, 1'b0, 1'b0, '0, '0);
        pkt = '{32'hFFFFFFFF};
        send_pkt(1, 1'b0, 1'b0, '0, '0);
        send_word('0, 1'b0, 1'b0, 1'b0, 0);

        // random packets with idle words in between
        for (int p = 0; p < 120; p++) begin
            int len;
            len = 1 + int'($urandom % 6);
            pkt.delete();
            for (int n = 0; n < len; n++) pkt.push_back($urandom);
            send_pkt(int'($urandom % 4), 1'b1, 1'b0, '0, '0);
            if ($urandom % 3 == 0) send_word($urandom, 1'b0, 1'b0, 1'b0, 0);
        end
        send_word('0, 1'b0, 1'b0, 1'b0, 0);
        repeat (10) @(negedge clk);
        for (int k = 0; k < 4; k++)   // R10: every ended packet produced its strobe
            check(exp_q[k].size() == 0, "R10", $sformatf("inst %0d pending results", k),
                  32'(exp_q[k].size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule